// File: doc/BRIEF.md
# On-Demand Clock Source Controller

This block decides when one oscillator clock source runs, and it gates the divided clock that the source feeds. Consumers raise request lines. When on-demand operation is selected, the source is switched on only while at least one request is active. After the last request drops, the source is switched off once a stop window has passed. The oscillator is modelled as an enable output. The source is taken as stable a programmed number of source cycles after that enable rises. The divided clock is passed on only after the source is stable and one full divided period has gone by. The divided clock is opened and closed only on its own period boundary.

Clearing the on-demand control keeps the source running whenever the block is enabled, so a request sees no startup delay. A standby indicator together with a run-in-standby control decides what happens in standby. With run-in-standby set, requests start and stop the source as usual. With it cleared, the source is forced off and requests are ignored. The controller runs from the free-running raw source clock. Requests and controls pass through a two-stage synchroniser. The clock-valid flag is resynchronised into the system clock domain for the consumers that read it.

Top module: `ondemand_clk_ctrl`

## Requirements
- R1: While reset is held, and directly after it is released, osc_en_o, src_rdy_o, div_clk_o and clk_valid_o are all 0.
- R2: Each request line passes through two source-clock flip-flops, and any single line can start the source. A request set up before source edge 1 raises osc_en_o after edge 3 and not after edge 2. With no request and on-demand set, the source stays off.
- R3: The startup counter restarts from zero each time osc_en_o rises. src_rdy_o rises exactly start_cnt_i+1 source cycles after osc_en_o rises, and it is low one cycle earlier.
- R4: The gate opens at the first divided-period boundary after src_rdy_o rises, which is exactly D = 2^DIV_LOG2 source cycles later. The wait from request to valid clock is therefore at least startup + 1 source period + 1 divided period.
- R5: Once the gate is open, div_clk_o has period D source cycles. It is low for the first D/2 cycles after each boundary and high for the last D/2.
- R6: After the last request drops (set up before edge 1), osc_en_o is still high after edge D+2 and low after edge D+3. Measured from the drop, the stop takes between D+1 and 2D+2 source periods.
- R7: When osc_en_o falls, src_rdy_o falls in the same cycle, the gate is already closed and div_clk_o is 0. clk_valid_o then goes to 0.
- R8: A request that reaches the controller during the stop window cancels the stop. osc_en_o and src_rdy_o then stay high without a new startup.
- R9: With on_demand_i at 0 and en_i at 1, the source runs whether or not requests are present. Toggling requests has no effect on osc_en_o, src_rdy_o or clk_valid_o.
- R10: In standby (stby_i=1) with run_stby_i=1, a request starts the source after edge 3, and dropping it stops the source after edge D+3.
- R11: In standby with run_stby_i=0, the source is forced off within the stop latency and requests are ignored. On leaving standby, a pending request starts the source after edge 3.
- R12: Clearing en_i stops the source after edge D+3 even while a request is active, and the source stays off while en_i is 0.
- R13: clk_valid_o is the gate state passed through two system-clock flip-flops. It is still 0 half a source cycle after the gate opens, and 1 a few system cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Free-running raw source clock; the controller runs on it |
| sys_clk_i | input | 1 | System clock for the clock-valid flag |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | One clock request per consumer |
| en_i | input | 1 | Source enable |
| on_demand_i | input | 1 | 1: run only on request; 0: run whenever enabled |
| run_stby_i | input | 1 | Allow operation while in standby |
| stby_i | input | 1 | Standby indicator |
| start_cnt_i | input | CNT_W | Startup count in source cycles (change only while the source is off) |
| osc_en_o | output | 1 | Oscillator enable |
| src_rdy_o | output | 1 | Source stable |
| div_clk_o | output | 1 | Gated divided clock |
| clk_valid_o | output | 1 | Divided clock valid, in the system clock domain |

## Verification
The hardest case to reach from the ports is a request that comes back inside the stop window. It has to reach the controller after the stop has begun and before the D-cycle countdown ends. The bench drives every input on the falling source edge and counts rising edges through the two-flop synchroniser, so the new request lands exactly three edges into a stop window of D edges. The forced-off standby case is reached by raising run-in-standby and lowering it again while a request is held. This shows that the same pending request is first honoured, then overridden, and then honoured again once standby ends.

// File: rtl/odc_pkg.sv
package odc_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_ON   = 2'd1,
    SRC_STOP = 2'd2
  } src_state_e;
endpackage

// File: rtl/odc_sync.sv
module odc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/odc_startup_timer.sv
module odc_startup_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  output logic             rdy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!osc_en_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == start_cnt_i) done_q <= 1'b1;
      else                      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // ready drops in the same cycle as the enable
  assign rdy_o = osc_en_i & done_q;

  a_r3_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_i) |-> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/odc_div_gate.sv
module odc_div_gate #(
  parameter int unsigned DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic open_i,
  output logic div_clk_o,
  output logic gate_o
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;
  logic                gate_q, gate_d;
  logic                clk_q, clk_d;
  logic                wrap_w;

  assign wrap_w = run_i && (cnt_q == '1);

  always_comb begin
    cnt_d  = run_i ? cnt_q + 1'b1 : '0;
    gate_d = gate_q;
    if (!run_i)      gate_d = 1'b0;
    else if (wrap_w) gate_d = open_i;
    // low half first after each boundary
    clk_d = gate_d & cnt_d[DIV_LOG2-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      gate_q <= gate_d;
      clk_q  <= clk_d;
    end
  end

  assign div_clk_o = clk_q;
  assign gate_o    = gate_q;

  a_r5_gate_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> ($past(wrap_w) || !$past(run_i)));
endmodule

// File: rtl/ondemand_clk_ctrl.sv
module ondemand_clk_ctrl
  import odc_pkg::*;
#(
  parameter int unsigned NUM_REQ     = 4,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned DIV_LOG2    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               src_clk_i,
  input  logic               sys_clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               en_i,
  input  logic               on_demand_i,
  input  logic               run_stby_i,
  input  logic               stby_i,
  input  logic [CNT_W-1:0]   start_cnt_i,
  output logic               osc_en_o,
  output logic               src_rdy_o,
  output logic               div_clk_o,
  output logic               clk_valid_o
);
  localparam int unsigned CFG_W = 4;
  localparam int unsigned IN_W  = NUM_REQ + CFG_W;

  logic [IN_W-1:0]    in_raw, in_s;
  logic [NUM_REQ-1:0] req_s;
  logic               en_s, od_s, rstby_s, stby_s;
  logic               forced_off_w, need_w, gate_w;

  src_state_e          state_q, state_d;
  logic [DIV_LOG2-1:0] stop_cnt_q, stop_cnt_d;

  assign in_raw = {stby_i, run_stby_i, on_demand_i, en_i, req_i};

  odc_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_raw),
    .q_o   (in_s)
  );

  assign req_s   = in_s[NUM_REQ-1:0];
  assign en_s    = in_s[NUM_REQ];
  assign od_s    = in_s[NUM_REQ+1];
  assign rstby_s = in_s[NUM_REQ+2];
  assign stby_s  = in_s[NUM_REQ+3];

  assign forced_off_w = stby_s & ~rstby_s;
  assign need_w       = en_s & ~forced_off_w & (~od_s | (|req_s));

  always_comb begin
    state_d    = state_q;
    stop_cnt_d = stop_cnt_q;
    unique case (state_q)
      SRC_OFF: if (need_w) state_d = SRC_ON;
      SRC_ON: begin
        if (!need_w) begin
          state_d    = SRC_STOP;
          stop_cnt_d = '0;
        end
      end
      SRC_STOP: begin
        // one full divided period: exactly one boundary closes the gate
        if (need_w)                 state_d    = SRC_ON;
        else if (stop_cnt_q == '1)  state_d    = SRC_OFF;
        else                        stop_cnt_d = stop_cnt_q + 1'b1;
      end
      default: state_d = SRC_OFF;
    endcase
  end

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SRC_OFF;
      stop_cnt_q <= '0;
    end else begin
      state_q    <= state_d;
      stop_cnt_q <= stop_cnt_d;
    end
  end

  assign osc_en_o = (state_q != SRC_OFF);

  odc_startup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (src_clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_o),
    .start_cnt_i(start_cnt_i),
    .rdy_o      (src_rdy_o)
  );

  odc_div_gate #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i    (src_clk_i),
    .rst_ni   (rst_ni),
    .run_i    (src_rdy_o),
    .open_i   (state_q == SRC_ON),
    .div_clk_o(div_clk_o),
    .gate_o   (gate_w)
  );

  odc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_valid_sync (
    .clk_i (sys_clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_w),
    .q_o   (clk_valid_o)
  );

  a_r4_open_only_when_on: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $rose(gate_w) |-> ($past(state_q) == SRC_ON));
  a_r7_gate_closed_at_stop: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (!gate_w && !src_rdy_o));
  a_r8_cancel_keeps_osc: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (state_q == SRC_STOP && need_w) |=> osc_en_o);
  a_r9_always_on: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (en_s && !od_s && !forced_off_w) |=> (state_q == SRC_ON));
  a_r11_forced_off: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    forced_off_w |=> (state_q != SRC_ON));
  a_r12_disable_stops: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    !en_s |=> (state_q != SRC_ON));
endmodule

// File: tb/ondemand_clk_ctrl_tb_top.sv
module ondemand_clk_ctrl_tb_top;
  localparam int SRC_PERIOD = 10;
  localparam int SYS_PERIOD = 14;
  localparam int NUM_REQ    = 4;
  localparam int CNT_W      = 8;
  localparam int DIV_LOG2   = 2;
  localparam int D          = 1 << DIV_LOG2;

  logic               src_clk = 1'b0;
  logic               sys_clk = 1'b0;
  logic               rst_n   = 1'b0;
  logic [NUM_REQ-1:0] req     = '0;
  logic               en = 1'b0, od = 1'b0, rstby = 1'b0, stby = 1'b0;
  logic [CNT_W-1:0]   start_cnt = '0;
  logic               osc_en, src_rdy, div_clk, clk_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #(SRC_PERIOD/2) src_clk = ~src_clk;
  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

  ondemand_clk_ctrl #(
    .NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2), .SYNC_STAGES(2)
  ) dut_i (
    .src_clk_i  (src_clk),
    .sys_clk_i  (sys_clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .en_i       (en),
    .on_demand_i(od),
    .run_stby_i (rstby),
    .stby_i     (stby),
    .start_cnt_i(start_cnt),
    .osc_en_o   (osc_en),
    .src_rdy_o  (src_rdy),
    .div_clk_o  (div_clk),
    .clk_valid_o(clk_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // n rising edges, then sample/drive at the following falling edge
  task automatic tick(input int n);
    repeat (n) begin
      @(posedge src_clk);
      @(negedge src_clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(SRC_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    summary();
    $finish;
  end

  initial begin
    int bad;
    chk("R1 osc_en in reset", int'(osc_en), 0);
    repeat (3) @(negedge src_clk);
    rst_n = 1'b1;
    chk("R1 osc_en after reset", int'(osc_en), 0);
    chk("R1 src_rdy after reset", int'(src_rdy), 0);
    chk("R1 div_clk after reset", int'(div_clk), 0);
    chk("R1 clk_valid after reset", int'(clk_valid), 0);

    en = 1'b1; od = 1'b1;
    tick(10);
    chk("R2 idle without request", int'(osc_en), 0);

    // sweep startup counts and request lines
    for (int n = 0; n < 8; n++) begin
      int line = n % NUM_REQ;
      start_cnt = CNT_W'(n);
      req[line] = 1'b1;
      tick(2);
      chk("R2 osc_en before sync", int'(osc_en), 0);
      tick(1);
      chk("R2 osc_en after sync", int'(osc_en), 1);
      chk("R3 rdy low at enable rise", int'(src_rdy), 0);
      tick(n);
      chk("R3 rdy one cycle early", int'(src_rdy), 0);
      tick(1);
      chk("R3 rdy at count+1", int'(src_rdy), 1);
      chk("R4 valid low at ready", int'(clk_valid), 0);
      tick(D - 1);
      chk("R4 gate closed before boundary", int'(div_clk), 0);
      for (int j = 0; j < 2 * D; j++) begin
        tick(1);
        chk("R5 divided waveform", int'(div_clk), ((j % D) >= D / 2) ? 1 : 0);
        if (j == 0) chk("R13 valid lags gate", int'(clk_valid), 0);
      end
      tick(3);
      chk("R13 valid after sync", int'(clk_valid), 1);
      req[line] = 1'b0;
      tick(D + 2);
      chk("R6 osc held in stop window", int'(osc_en), 1);
      tick(1);
      chk("R6 osc off at stop bound", int'(osc_en), 0);
      chk("R7 rdy cleared with enable", int'(src_rdy), 0);
      chk("R7 div_clk quiet", int'(div_clk), 0);
      tick(5);
      chk("R7 valid cleared", int'(clk_valid), 0);
    end

    // R8: cancel inside the stop window
    start_cnt = 8'd2;
    req[0] = 1'b1;
    tick(20);
    chk("R8 running before cancel", int'(src_rdy), 1);
    req[0] = 1'b0;
    tick(3);
    req[0] = 1'b1;
    bad = 0;
    repeat (20) begin
      tick(1);
      if (!osc_en || !src_rdy) bad++;
    end
    chk("R8 no restart after cancel", bad, 0);
    req[0] = 1'b0;
    tick(D + 5);
    chk("R8 stops after final drop", int'(osc_en), 0);

    // R9: on-demand cleared
    od = 1'b0;
    tick(2);
    chk("R9 osc before sync", int'(osc_en), 0);
    tick(1);
    chk("R9 osc runs without request", int'(osc_en), 1);
    tick(20);
    chk("R9 rdy without request", int'(src_rdy), 1);
    req[1] = 1'b1;
    tick(5);
    req[1] = 1'b0;
    bad = 0;
    repeat (20) begin
      tick(1);
      if (!osc_en || !src_rdy || !clk_valid) bad++;
    end
    chk("R9 requests have no effect", bad, 0);

    // R12: enable cleared with an active request
    od = 1'b1; req[2] = 1'b1; en = 1'b0;
    tick(D + 2);
    chk("R12 osc in stop window", int'(osc_en), 1);
    tick(1);
    chk("R12 osc off after disable", int'(osc_en), 0);
    tick(10);
    chk("R12 stays off while disabled", int'(osc_en), 0);
    req[2] = 1'b0; en = 1'b1;
    tick(5);

    // R10/R11: standby
    stby = 1'b1; rstby = 1'b0;
    tick(4);
    req[3] = 1'b1;
    bad = 0;
    repeat (20) begin
      tick(1);
      if (osc_en) bad++;
    end
    chk("R11 requests ignored in standby", bad, 0);
    rstby = 1'b1;
    tick(2);
    chk("R10 osc before sync", int'(osc_en), 0);
    tick(1);
    chk("R10 request honoured in standby", int'(osc_en), 1);
    tick(20);
    chk("R10 rdy in standby", int'(src_rdy), 1);
    req[3] = 1'b0;
    tick(D + 2);
    chk("R10 osc in stop window", int'(osc_en), 1);
    tick(1);
    chk("R10 stop in standby", int'(osc_en), 0);
    req[3] = 1'b1;
    tick(20);
    chk("R10 restart in standby", int'(src_rdy), 1);
    rstby = 1'b0;
    tick(D + 2);
    chk("R11 osc in stop window", int'(osc_en), 1);
    tick(1);
    chk("R11 forced off", int'(osc_en), 0);
    stby = 1'b0;
    tick(2);
    chk("R11 still off before sync", int'(osc_en), 0);
    tick(1);
    chk("R11 pending request resumes", int'(osc_en), 1);
    req[3] = 1'b0;
    tick(D + 5);
    chk("R6 final stop", int'(osc_en), 0);

    summary();
    $finish;
  end
endmodule